// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block arbitrates device interrupt requests against a processor status word. Each request line has a fixed 3-bit level, set by a parameter. A priority encoder picks the highest pending level. A comparator accepts the request only when that level is strictly above the priority field of the status word held inside the block.

When a request is accepted, the block does four things in one registered step:
- it emits a one-cycle grant pulse with an 8-bit vector;
- it presents the unmodified status word so that software can push it;
- it switches the status word to supervisor mode;
- it raises the priority field to its maximum, which masks every device until software lowers it.

A return-from-interrupt strobe loads a whole new status word. This is also how software changes the priority level at any time. The strobe is honoured only in supervisor mode. In user mode it raises a privilege-violation pulse and leaves the status word unchanged.

Status word layout: bit 15 is the user/supervisor flag (1 = user), bits [10:8] hold the priority level, and bits [2:0] hold the N/Z/P condition codes.

Top module: `pie_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `psr_q` is 16'h0700 (supervisor, level 7, condition codes 0), and `irq_grant` and `priv_viol` are 0.
- R2: A request is granted only when the highest pending device level is strictly greater than `psr_q[10:8]`. A pending level equal to the field produces no grant.
- R3: The highest pending level wins. Among pending devices at the same level, the lowest-numbered device wins.
- R4: `irq_grant` is high for exactly one cycle, in the cycle after the qualifying request is sampled. In that cycle `irq_vec` equals VEC_BASE (default 8'h80) plus the winning device index.
- R5: In the grant cycle, `psr_q` has bit 15 cleared and bits [10:8] set to 3'b111. All other bits keep their pre-grant values.
- R6: In the grant cycle, `saved_psr` holds the status word as it was just before the grant.
- R7: While `psr_q[10:8]` is 3'b111, no request produces a grant.
- R8: A `rti_valid` strobe sampled with `psr_q[15]` = 0 loads all 16 bits of `rti_psr` into `psr_q`, visible in the next cycle.
- R9: A `rti_valid` strobe sampled with `psr_q[15]` = 1 leaves `psr_q` unchanged and raises `priv_viol` for one cycle in the next cycle.
- R10: A cycle in which `rti_valid` is high never starts a grant. A pending request is evaluated against the restored word in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_DEV | Device interrupt requests, one per device |
| rti_valid | input | 1 | Return-from-interrupt strobe |
| rti_psr | input | 16 | Status word to restore on return |
| psr_q | output | 16 | Current status word |
| irq_grant | output | 1 | One-cycle interrupt grant pulse |
| irq_vec | output | 8 | Vector of the granted device |
| saved_psr | output | 16 | Pre-grant status word, valid with the grant |
| priv_viol | output | 1 | Return attempted in user mode |

## Verification
On every cycle, the assertions check the following:
- that a grant is a lone pulse;
- that the status word in the grant cycle is supervisor at level 7;
- that the saved word matches the previous status word;
- that a return-from-interrupt never coincides with starting a grant;
- that a supervisor return loads the word exactly;
- that a user-mode return only flags a violation.

Which device wins, and its vector, depend on the parameterised level map. Only the bench's scenarios show these cases:
- tie-breaking at equal levels;
- the equal-level refusal;
- masking at level 7.

// File: rtl/pie_pkg.sv
package pie_pkg;
    localparam int STAT_W  = 16;
    localparam int PRIO_W  = 3;
    localparam int VEC_W   = 8;
    localparam logic [STAT_W-1:0] RESET_STAT = 16'h0700;

    typedef logic [PRIO_W-1:0] level_t;

    // status word: user flag at 15, level at [10:8], N/Z/P at [2:0]
    typedef struct packed {
        logic       user;
        logic [3:0] rsv_hi;
        level_t     prio;
        logic [4:0] rsv_lo;
        logic [2:0] cc;
    } stat_t;

    function automatic stat_t enter_irq(stat_t s);
        stat_t r;
        r      = s;
        r.user = 1'b0;
        r.prio = '1;
        return r;
    endfunction
endpackage

// File: rtl/pie_prio_enc.sv
module pie_prio_enc
    import pie_pkg::*;
#(
    parameter int NUM_DEV = 8,
    parameter logic [NUM_DEV*PRIO_W-1:0] LEVELS = '0,
    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic [NUM_DEV-1:0] req,
    output logic               any,
    output level_t             lvl,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        lvl = '0;
        idx = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            // strict compare keeps the lower index on a tie
            if (req[i] && (!any || LEVELS[i*PRIO_W +: PRIO_W] > lvl)) begin
                any = 1'b1;
                lvl = LEVELS[i*PRIO_W +: PRIO_W];
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pie_stat_reg.sv
module pie_stat_reg
    import pie_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_irq,
    input  logic  rti_valid,
    input  stat_t rti_word,
    output stat_t stat_q,
    output logic  viol_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= stat_t'(RESET_STAT);
            viol_q <= 1'b0;
        end else begin
            viol_q <= 1'b0;
            if (rti_valid) begin
                if (stat_q.user) viol_q <= 1'b1;
                else             stat_q <= rti_word;
            end else if (take_irq) begin
                stat_q <= enter_irq(stat_q);
            end
        end
    end
endmodule

// File: rtl/pie_ctrl.sv
module pie_ctrl
    import pie_pkg::*;
#(
    parameter int NUM_DEV = 8,
    parameter logic [NUM_DEV*3-1:0] LEVELS =
        {3'd5, 3'd7, 3'd3, 3'd6, 3'd2, 3'd4, 3'd4, 3'd1},
    parameter logic [7:0] VEC_BASE = 8'h80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DEV-1:0] irq_req,
    input  logic               rti_valid,
    input  logic [15:0]        rti_psr,
    output logic [15:0]        psr_q,
    output logic               irq_grant,
    output logic [7:0]         irq_vec,
    output logic [15:0]        saved_psr,
    output logic               priv_viol
);
    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic             enc_any;
    level_t           enc_lvl;
    logic [IDX_W-1:0] enc_idx;
    stat_t            stat;
    logic             take_irq;

    pie_prio_enc #(.NUM_DEV(NUM_DEV), .LEVELS(LEVELS)) u_enc (
        .req (irq_req),
        .any (enc_any),
        .lvl (enc_lvl),
        .idx (enc_idx)
    );

    assign take_irq = enc_any && (enc_lvl > stat.prio) && !rti_valid;

    pie_stat_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .take_irq  (take_irq),
        .rti_valid (rti_valid),
        .rti_word  (stat_t'(rti_psr)),
        .stat_q    (stat),
        .viol_q    (priv_viol)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_grant <= 1'b0;
            irq_vec   <= '0;
            saved_psr <= '0;
        end else begin
            irq_grant <= take_irq;
            if (take_irq) begin
                irq_vec   <= VEC_BASE + VEC_W'(enc_idx);
                saved_psr <= stat;
            end
        end
    end

    assign psr_q = stat;
endmodule

// File: rtl/pie_chk.sv
module pie_chk #(
    parameter int NUM_DEV = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_DEV-1:0] irq_req,
    input logic               rti_valid,
    input logic [15:0]        rti_psr,
    input logic [15:0]        psr_q,
    input logic               irq_grant,
    input logic [15:0]        saved_psr,
    input logic               priv_viol
);
    // R4
    grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_grant |=> !irq_grant);
    // R5
    grant_state_chk: assert property (@(posedge clk) disable iff (rst)
        irq_grant |-> (psr_q[15] == 1'b0 && psr_q[10:8] == 3'b111));
    // R6
    saved_word_chk: assert property (@(posedge clk) disable iff (rst)
        irq_grant |-> saved_psr == $past(psr_q));
    // R7
    masked_level_chk: assert property (@(posedge clk) disable iff (rst)
        (psr_q[10:8] == 3'b111) |=> !irq_grant);
    // R8
    rti_load_chk: assert property (@(posedge clk) disable iff (rst)
        (rti_valid && !psr_q[15]) |=> psr_q == $past(rti_psr));
    // R9
    rti_viol_chk: assert property (@(posedge clk) disable iff (rst)
        (rti_valid && psr_q[15]) |=> (priv_viol && $stable(psr_q)));
    // R10
    rti_first_chk: assert property (@(posedge clk) disable iff (rst)
        rti_valid |=> !irq_grant);
    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        irq_grant |-> $past(|irq_req));
endmodule

bind pie_ctrl pie_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .rti_valid (rti_valid),
    .rti_psr   (rti_psr),
    .psr_q     (psr_q),
    .irq_grant (irq_grant),
    .saved_psr (saved_psr),
    .priv_viol (priv_viol)
);

// File: tb/sim_pie_ctrl.sv
`timescale 1ns/1ps
module sim_pie_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  irq_req = '0;
    logic        rti_valid = 1'b0;
    logic [15:0] rti_psr = '0;
    logic [15:0] psr_q, saved_psr;
    logic        irq_grant, priv_viol;
    logic [7:0]  irq_vec;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    // device levels: d0=1 d1=4 d2=4 d3=2 d4=6 d5=3 d6=7 d7=5
    pie_ctrl #(.NUM_DEV(8),
               .LEVELS({3'd5, 3'd7, 3'd3, 3'd6, 3'd2, 3'd4, 3'd4, 3'd1}),
               .VEC_BASE(8'h80)) u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .rti_valid(rti_valid),
        .rti_psr(rti_psr), .psr_q(psr_q), .irq_grant(irq_grant),
        .irq_vec(irq_vec), .saved_psr(saved_psr), .priv_viol(priv_viol)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_rti(logic [15:0] w);
        rti_valid = 1'b1;
        rti_psr   = w;
        step();
        rti_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "psr", psr_q, 16'h0700);
        chk("R1", "grant", {15'd0, irq_grant}, 16'd0);
        chk("R1", "viol", {15'd0, priv_viol}, 16'd0);
    endtask

    task automatic t_masked();
        irq_req = 8'hFF;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R7", "grant at level 7", {15'd0, irq_grant}, 16'd0);
        end
        irq_req = '0;
        step();
    endtask

    task automatic t_rti_load();
        do_rti(16'h0205);
        chk("R8", "full load", psr_q, 16'h0205);
    endtask

    task automatic t_compare();
        irq_req = 8'h08;
        step();
        chk("R2", "equal level no grant", {15'd0, irq_grant}, 16'd0);
        irq_req = 8'h20;
        step();
        chk("R2", "grant above level", {15'd0, irq_grant}, 16'd1);
        chk("R4", "vector", {8'd0, irq_vec}, 16'h0085);
        chk("R5", "entered psr", psr_q, 16'h0705);
        chk("R6", "saved psr", saved_psr, 16'h0205);
        step();
        chk("R4", "pulse ends", {15'd0, irq_grant}, 16'd0);
        irq_req = '0;
        step();
    endtask

    task automatic t_order();
        do_rti(16'h0000);
        irq_req = 8'h07;
        step();
        chk("R3", "tie lowest index", {8'd0, irq_vec}, 16'h0081);
        irq_req = '0;
        step();
        do_rti(16'h0000);
        irq_req = 8'h91;
        step();
        chk("R3", "highest level", {8'd0, irq_vec}, 16'h0084);
        irq_req = '0;
        step();
    endtask

    task automatic t_user();
        do_rti(16'h8100);
        chk("R8", "user load", psr_q, 16'h8100);
        do_rti(16'h0000);
        chk("R9", "violation flag", {15'd0, priv_viol}, 16'd1);
        chk("R9", "psr kept", psr_q, 16'h8100);
        step();
        chk("R9", "flag one cycle", {15'd0, priv_viol}, 16'd0);
        irq_req = 8'h08;
        step();
        chk("R5", "user to supervisor", psr_q, 16'h0700);
        chk("R6", "saved user word", saved_psr, 16'h8100);
        irq_req = '0;
        step();
    endtask

    task automatic t_rti_first();
        irq_req   = 8'h10;
        rti_valid = 1'b1;
        rti_psr   = 16'h0000;
        step();
        rti_valid = 1'b0;
        chk("R10", "no grant with rti", {15'd0, irq_grant}, 16'd0);
        chk("R10", "restored", psr_q, 16'h0000);
        step();
        chk("R10", "grant after restore", {15'd0, irq_grant}, 16'd1);
        chk("R10", "vector", {8'd0, irq_vec}, 16'h0084);
        irq_req = '0;
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        t_reset();
        step();
        t_reset();
        t_masked();
        t_rti_load();
        t_compare();
        t_order();
        t_user();
        t_rti_first();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule